// File: doc/BRIEF.md
# Signaling PCM Stream Generator

This block turns per-channel robbed-bit signaling into a serial signaling-PCM stream that runs bit for bit beside the backplane data stream. Once per receive multiframe, a parallel snapshot of all channels' A/B/C/D bits is offered together with a one-cycle tick. That snapshot updates a pending buffer, either at once or only after the new value has stayed steady across several multiframes. At the next output multiframe boundary, which is marked by an external multiframe sync, the pending buffer is copied into the active buffer. The serializer reads only the active buffer.

The output frame has 193 bit slots, and each slot lasts one backplane clock. Slot 0 is the framing slot and always carries a zero. Channel c fills slots 1+8c through 8+8c, with bit 1 of the word sent first. The upper half of each channel word is zero. The lower half carries the signaling bits. In ESF mode these are A, B, C and D. In D4 mode they are A, B, A and B. A freeze input blocks updates of the pending buffer, so the previously accepted values keep going out.

Top module: `sig_pcm_gen`

## Requirements
- R1: While reset is held, and after it until the first accepted update reaches the active buffer, every output bit is 0.
- R2: `fsync_i` high marks the current clock as slot 0 of a frame. The output for a slot appears one clock later. Slot 0 outputs 0. Channel c occupies slots 1+8c to 8+8c, with word bit 1 first.
- R3: Word bits 1 to 4 of every channel are 0.
- R4: In ESF mode (`esf_mode_i`=1), word bits 5, 6, 7 and 8 of channel c carry A, B, C and D. These are `rx_sig_i` bits 4c+3, 4c+2, 4c+1 and 4c+0.
- R5: In D4 mode (`esf_mode_i`=0), word bits 5 to 8 carry A, B, A and B, so bit 7 equals bit 5 and bit 8 equals bit 6.
- R6: A tick on `rx_tick_i` updates only the pending buffer. The active buffer takes the pending value only in a cycle where `fsync_i` and `msync_i` are both high. If a tick falls in that same cycle, the active buffer takes the value pending before the tick.
- R7: A tick seen while `freeze_i` is high is ignored. The pending buffer and the debounce state stay unchanged.
- R8: With `integ_en_i`=1, a channel's pending value changes only after 3 consecutive unfrozen ticks present the same new value. Any different value restarts the count. A value equal to the pending one clears the count.
- R9: With `integ_en_i`=0, every unfrozen tick loads the snapshot into pending directly for all channels. The integration setting applies to all channels at once.
- R10: Without `fsync_i`, the slot counter runs freely and wraps from slot 192 to slot 0, so the frame layout repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync; high in the framing slot |
| msync_i | input | 1 | Output multiframe sync; applies when high together with `fsync_i` |
| esf_mode_i | input | 1 | 1 = ESF nibble packing, 0 = D4 |
| freeze_i | input | 1 | Suppresses pending-buffer updates |
| integ_en_i | input | 1 | Global three-multiframe integration enable |
| rx_tick_i | input | 1 | Receive multiframe boundary; samples `rx_sig_i` |
| rx_sig_i | input | 96 | Signaling snapshot, channel c in bits 4c+3..4c (A in the MSB) |
| sig_pcm_o | output | 1 | Serial signaling-PCM output |

## Verification
A receive tick and the output multiframe boundary can land on the same clock. In that cycle the pending buffer is written while the active buffer copies it. The bench drives a tick in slot 0 of a frame that also carries the multiframe sync. It expects that multiframe to keep sending the older values and the following multiframe to send the new ones. Random frames also place ticks and boundaries freely, including slot 0. A bench model of the pending and active buffers checks every slot of each frame.

// File: rtl/sig_pcm_pkg.sv
package sig_pcm_pkg;
    localparam int SIG_W  = 4;
    localparam int WORD_W = 8;
    typedef logic [SIG_W-1:0] abcd_t;
endpackage

// File: rtl/sig_pcm_slot_ctr.sv
module sig_pcm_slot_ctr #(
    parameter int FRAME_BITS = 193,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    output logic [POS_W-1:0] pos_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [POS_W-1:0] cur_pos;

    always_comb begin
        cur_pos = fsync_i ? '0 : ctr_q.pos;
        ctr_d   = ctr_q;
        if (cur_pos == POS_W'(FRAME_BITS - 1)) ctr_d.pos = '0;
        else                                    ctr_d.pos = cur_pos + POS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign pos_o = cur_pos;

    // R10: the counter stays inside the frame and wraps
    a_r10_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.pos < POS_W'(FRAME_BITS));
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_i && ctr_q.pos == POS_W'(FRAME_BITS - 1)) |=> ctr_q.pos == '0);
endmodule

// File: rtl/sig_pcm_debounce.sv
module sig_pcm_debounce
    import sig_pcm_pkg::*;
#(
    parameter int DEB_MF = 3,
    localparam int CNT_W = $clog2(DEB_MF + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  freeze_i,
    input  logic  integ_en_i,
    input  abcd_t rx_i,
    output abcd_t pend_o
);
    typedef struct packed {
        abcd_t            pend;
        abcd_t            cand;
        logic [CNT_W-1:0] cnt;
    } deb_t;

    deb_t deb_d, deb_q;
    logic [CNT_W-1:0] seen;

    always_comb begin
        deb_d = deb_q;
        seen  = (rx_i == deb_q.cand) ? deb_q.cnt + CNT_W'(1) : CNT_W'(1);
        if (tick_i && !freeze_i) begin
            if (!integ_en_i || rx_i == deb_q.pend) begin
                deb_d.pend = integ_en_i ? deb_q.pend : rx_i;
                deb_d.cand = rx_i;
                deb_d.cnt  = '0;
            end else if (seen >= CNT_W'(DEB_MF)) begin
                deb_d.pend = rx_i;
                deb_d.cand = rx_i;
                deb_d.cnt  = '0;
            end else begin
                deb_d.cand = rx_i;
                deb_d.cnt  = seen;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) deb_q <= '0;
        else        deb_q <= deb_d;
    end

    assign pend_o = deb_q.pend;

    // R7: a frozen or absent tick leaves pending and debounce state alone
    a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i || freeze_i) |=> ($stable(deb_q.pend) && $stable(deb_q.cnt)));
    // R8: the hold count never reaches the commit threshold as stored state
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        deb_q.cnt < CNT_W'(DEB_MF));
    // R9: without integration a tick loads the snapshot directly
    a_r9_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_i && !integ_en_i) |=> pend_o == $past(rx_i));
endmodule

// File: rtl/sig_pcm_serializer.sv
module sig_pcm_serializer
    import sig_pcm_pkg::*;
#(
    parameter int N_CH = 24,
    localparam int FRAME_BITS = N_CH * WORD_W + 1,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [POS_W-1:0]      pos_i,
    input  logic                  esf_mode_i,
    input  logic [N_CH*SIG_W-1:0] active_i,
    output logic                  bit_o
);
    typedef struct packed {
        logic bit_v;
    } ser_t;

    ser_t ser_d, ser_q;
    logic [POS_W-1:0] idx;
    logic [POS_W-1:0] ch;
    logic [2:0]       k;
    abcd_t            nib;

    always_comb begin
        idx   = pos_i - POS_W'(1);
        ch    = idx >> 3;
        k     = idx[2:0];
        nib   = active_i[{ch, 2'b00} +: SIG_W];
        ser_d = ser_q;
        if (pos_i == '0 || !k[2]) begin
            ser_d.bit_v = 1'b0;
        end else begin
            unique case (k[1:0])
                2'd0:    ser_d.bit_v = nib[3];
                2'd1:    ser_d.bit_v = nib[2];
                2'd2:    ser_d.bit_v = esf_mode_i ? nib[1] : nib[3];
                default: ser_d.bit_v = esf_mode_i ? nib[0] : nib[2];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign bit_o = ser_q.bit_v;

    // R3: upper half of every channel word goes out as zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i != '0 && idx[2] == 1'b0) |=> !bit_o);
endmodule

// File: rtl/sig_pcm_gen.sv
module sig_pcm_gen
    import sig_pcm_pkg::*;
#(
    parameter int N_CH   = 24,
    parameter int DEB_MF = 3,
    localparam int FRAME_BITS = N_CH * WORD_W + 1,
    localparam int POS_W = $clog2(FRAME_BITS),
    localparam int BUS_W = N_CH * SIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  logic             msync_i,
    input  logic             esf_mode_i,
    input  logic             freeze_i,
    input  logic             integ_en_i,
    input  logic             rx_tick_i,
    input  logic [BUS_W-1:0] rx_sig_i,
    output logic             sig_pcm_o
);
    typedef struct packed {
        logic [BUS_W-1:0] active;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [BUS_W-1:0] pend;
    logic [POS_W-1:0] pos;
    logic             mf_edge;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        sig_pcm_debounce #(.DEB_MF(DEB_MF)) deb_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (rx_tick_i),
            .freeze_i   (freeze_i),
            .integ_en_i (integ_en_i),
            .rx_i       (rx_sig_i[c*SIG_W +: SIG_W]),
            .pend_o     (pend[c*SIG_W +: SIG_W])
        );
    end

    sig_pcm_slot_ctr #(.FRAME_BITS(FRAME_BITS)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync_i),
        .pos_o   (pos)
    );

    assign mf_edge = fsync_i && msync_i;

    always_comb begin
        buf_d = buf_q;
        if (mf_edge) buf_d.active = pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    sig_pcm_serializer #(.N_CH(N_CH)) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_i      (pos),
        .esf_mode_i (esf_mode_i),
        .active_i   (buf_q.active),
        .bit_o      (sig_pcm_o)
    );

    // R2: framing slot output is zero
    a_r2_frame_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> !sig_pcm_o);
    // R6: active buffer moves only at the output multiframe boundary
    a_r6_swap_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsync_i && msync_i) |=> $stable(buf_q.active));
    a_r6_takes_old_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_i && msync_i) |=> buf_q.active == $past(pend));
endmodule

// File: tb/sig_pcm_gen_tb.sv
module sig_pcm_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 24;
    localparam int FB  = 193;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync_i = 0, msync_i = 0, esf_mode_i = 1, freeze_i = 0;
    logic        integ_en_i = 0, rx_tick_i = 0;
    logic [95:0] rx_sig_i = '0;
    logic        sig_pcm_o;

    int errors = 0;
    int checks = 0;
    logic got [0:FB-1];

    logic [95:0] m_pend = '0, m_cand = '0, m_act = '0;
    int          m_cnt [0:NCH-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_pcm_gen dut_i (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .msync_i(msync_i),
        .esf_mode_i(esf_mode_i), .freeze_i(freeze_i), .integ_en_i(integ_en_i),
        .rx_tick_i(rx_tick_i), .rx_sig_i(rx_sig_i), .sig_pcm_o(sig_pcm_o)
    );

    function automatic logic exp_bit(int slot, logic [95:0] act, logic esf);
        int idx, ch, k;
        logic [3:0] nib;
        if (slot == 0) return 1'b0;
        idx = slot - 1; ch = idx / 8; k = idx % 8;
        if (k < 4) return 1'b0;
        nib = act[ch*4 +: 4];
        case (k)
            4: return nib[3];
            5: return nib[2];
            6: return esf ? nib[1] : nib[3];
            default: return esf ? nib[0] : nib[2];
        endcase
    endfunction

    task automatic model_tick(logic [95:0] rx, logic frz, logic integ);
        if (frz) return;
        for (int c = 0; c < NCH; c++) begin
            logic [3:0] v;
            int n;
            v = rx[c*4 +: 4];
            if (!integ || v == m_pend[c*4 +: 4]) begin
                if (!integ) m_pend[c*4 +: 4] = v;
                m_cand[c*4 +: 4] = v; m_cnt[c] = 0;
            end else begin
                n = (v == m_cand[c*4 +: 4]) ? m_cnt[c] + 1 : 1;
                if (n >= 3) begin
                    m_pend[c*4 +: 4] = v; m_cand[c*4 +: 4] = v; m_cnt[c] = 0;
                end else begin
                    m_cand[c*4 +: 4] = v; m_cnt[c] = n;
                end
            end
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one 193-slot frame; starts and ends at a falling edge.
    task automatic run_frame(bit use_fs, bit ms, int tick_at,
                             logic [95:0] rx, bit frz, string req);
        int bad_slot, bad_act, bad_exp, up_bad;
        for (int i = 0; i < FB; i++) begin
            fsync_i   = use_fs && (i == 0);
            msync_i   = ms && (i == 0);
            rx_tick_i = (i == tick_at);
            freeze_i  = frz;
            rx_sig_i  = rx;
            if (fsync_i && msync_i) m_act = m_pend;
            if (rx_tick_i) model_tick(rx, frz, integ_en_i);
            @(posedge clk);
            @(negedge clk);
            got[i] = sig_pcm_o;
        end
        fsync_i = 0; msync_i = 0; rx_tick_i = 0; freeze_i = 0;
        check(got[0] == 1'b0, "R2", "framing slot", int'(got[0]), 0);
        up_bad = 0; bad_slot = -1; bad_act = 0; bad_exp = 0;
        for (int s = 1; s < FB; s++) begin
            if (((s - 1) % 8) < 4) begin
                if (got[s] !== 1'b0) up_bad++;
            end else if (got[s] !== exp_bit(s, m_act, esf_mode_i) && bad_slot < 0) begin
                bad_slot = s; bad_act = int'(got[s]);
                bad_exp = int'(exp_bit(s, m_act, esf_mode_i));
            end
        end
        check(up_bad == 0, "R3", "upper nibble ones", up_bad, 0);
        if (bad_slot >= 0)
            $display("  slot %0d mismatch in %s frame", bad_slot, req);
        check(bad_slot < 0, req, "signaling nibble bit", bad_act, bad_exp);
    endtask

    function automatic logic [95:0] rnd96();
        return {$urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [95:0] ra, rb, rc, rd;
        logic [95:0] pool [0:2];
        for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(sig_pcm_o == 1'b0, "R1", "output in reset", int'(sig_pcm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: nothing accepted yet, all zeros after the first boundary
        run_frame(1, 1, -1, '0, 0, "R1");

        // R6: tick alone does not reach the output; R4 after boundary
        ra = rnd96();
        run_frame(1, 0, 50, ra, 0, "R6");
        run_frame(1, 0, -1, ra, 0, "R6");
        run_frame(1, 1, -1, ra, 0, "R4");
        // R10: free-running counter without fsync
        run_frame(0, 0, -1, ra, 0, "R10");
        // R5: D4 packing
        esf_mode_i = 0;
        run_frame(1, 0, -1, ra, 0, "R5");

        // R7: frozen tick ignored
        rb = rnd96();
        run_frame(1, 0, 10, rb, 1, "R7");
        run_frame(1, 1, -1, rb, 0, "R7");

        // R6: tick coincident with the boundary
        run_frame(1, 1, 0, rb, 0, "R6");
        run_frame(1, 1, -1, rb, 0, "R6");

        // R8: integration with an interruption
        esf_mode_i = 1; integ_en_i = 1;
        rc = rnd96(); rd = rnd96();
        run_frame(1, 0, 20, rc, 0, "R8");
        run_frame(1, 1, -1, rc, 0, "R8");
        run_frame(1, 0, 20, rc, 0, "R8");
        run_frame(1, 0, 20, rd, 0, "R8");
        run_frame(1, 0, 20, rc, 0, "R8");
        run_frame(1, 0, 20, rc, 0, "R8");
        run_frame(1, 1, -1, rc, 0, "R8");
        run_frame(1, 0, 20, rc, 0, "R8");
        run_frame(1, 1, -1, rc, 0, "R8");

        // R9: integration off, direct load
        integ_en_i = 0;
        run_frame(1, 0, 90, rd, 0, "R9");
        run_frame(1, 1, -1, rd, 0, "R9");

        // Random mix
        pool[0] = rnd96(); pool[1] = rnd96(); pool[2] = rnd96();
        for (int f = 0; f < 30; f++) begin
            esf_mode_i = 1'($urandom % 2);
            integ_en_i = ($urandom % 3) != 0;
            run_frame(1, ($urandom % 2) == 1,
                      (($urandom % 4) == 0) ? 0 : int'($urandom % FB),
                      pool[$urandom % 3], ($urandom % 5) == 0,
                      esf_mode_i ? "R4" : "R5");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule